// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Instruction Sequencer

This block sequences a small core whose instructions are all 14 bits wide, so a single program-memory read returns one complete instruction. While one instruction is held in a holding register and presented for execution, the next one is already being read from program memory at the address held in the program counter. The datapath, ALU and register file sit outside this block. They consume the executing instruction and its valid flag, and they supply a test bit for conditional skips.

Three instruction classes change the flow. An unconditional jump loads the program counter with an address taken from the instruction word. A conditional skip passes over the following instruction when the tested bit is clear. A taken jump or a taken skip discards the instruction that was fetched behind it. In its place comes one null cycle, during which nothing executes and the next useful instruction is fetched. Every other instruction, including the all-zero no-operation word, takes exactly one cycle.

Program memory is read combinationally: `pmem_data` must reflect `pmem_addr` within the same cycle.

Top module: `fetch_exec_seq`

## Requirements
- R1: While `rst_n` is low, `pmem_addr` is 0 and `exec_valid` is low. The first cycle after release is a null cycle that fetches address 0, and the word at address 0 executes in the second cycle.
- R2: An instruction that is neither a jump nor a taken skip executes in one cycle. In the next cycle `pmem_addr` is one higher and `exec_valid` is high. The no-operation word (all zero) and every opcode other than 3'b101 and 3'b010 count as such instructions.
- R3: The word present on `pmem_data` while `pmem_addr` equals A is the instruction shown on `exec_instr` in the following cycle, unless that cycle is a null cycle.
- R4: A jump has opcode 3'b101 in bits [13:11] and its target in bits [10:0]. In the cycle after the jump executes, `pmem_addr` equals the target and `exec_valid` is low. The word at the target executes in the cycle after that, so a jump occupies two cycles.
- R5: A skip has opcode 3'b010 in bits [13:11]. When `test_bit` is low during the skip's execution cycle, the next cycle is a null cycle that squashes the following instruction, and the instruction two addresses past the skip executes after that.
- R6: When `test_bit` is high during a skip's execution cycle, the skip takes one cycle and the following instruction executes in the next cycle.
- R7: In every cycle in which `exec_valid` is low, `exec_instr` is all zero.
- R8: The program counter advances from 2047 (all ones) to 0 without a null cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pmem_addr | output | 11 | Program memory read address (the program counter) |
| pmem_data | input | 14 | Program memory word at `pmem_addr`, same cycle |
| test_bit | input | 1 | Bit tested by a skip in its execution cycle |
| exec_instr | output | 14 | Instruction executing this cycle, zero in a null cycle |
| exec_valid | output | 1 | High when `exec_instr` is a real executing instruction |

## Verification
The bench builds the block with its default widths: 14-bit instructions and an 11-bit program counter. This gives a full 2048-word program store that the bench can fill completely. Random jump targets can land anywhere in that space, and a directed program reaches address 2047 so that the wrap to 0 can be observed. Random skips combined with a random test bit exercise both the taken and the untaken outcome, including a skip that arrives directly after a null cycle.

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq #(
  parameter int IW = 14,
  parameter int AW = 11,
  parameter int OPW = 3,
  parameter logic [OPW-1:0] OP_JMP = 3'b101,
  parameter logic [OPW-1:0] OP_SKC = 3'b010
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] pmem_addr,
  input  logic [IW-1:0] pmem_data,
  input  logic          test_bit,
  output logic [IW-1:0] exec_instr,
  output logic          exec_valid
);
  localparam int OPLSB = IW - OPW;

  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic          ir_ok;

  wire [OPW-1:0] op        = ir[IW-1:OPLSB];
  wire           is_jmp    = ir_ok && (op == OP_JMP);
  wire           is_skc    = ir_ok && (op == OP_SKC);
  wire           skip_take = is_skc && !test_bit;
  wire           flush     = is_jmp || skip_take;
  wire [AW-1:0]  pc_next   = is_jmp ? ir[AW-1:0] : pc + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      ir    <= '0;
      ir_ok <= 1'b0;
    end else begin
      pc    <= pc_next;
      ir    <= pmem_data;
      ir_ok <= !flush;
    end
  end

  assign pmem_addr  = pc;
  assign exec_valid = ir_ok;
  assign exec_instr = ir_ok ? ir : '0;

  AST_NULL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_valid |=> exec_valid); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !is_jmp && !skip_take) |=>
      (exec_valid && pmem_addr == $past(pmem_addr) + AW'(1))); // R2

  AST_FETCH_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !is_jmp && !skip_take) |=> (exec_instr == $past(pmem_data))); // R3

  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    is_jmp |=> (!exec_valid && pmem_addr == $past(exec_instr[AW-1:0]))); // R4

  AST_SKIP_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (is_skc && !test_bit) |=> (!exec_valid && pmem_addr == $past(pmem_addr) + AW'(1))); // R5

  AST_SKIP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_skc && test_bit) |=> exec_valid); // R6

  AST_NULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exec_valid) |-> (exec_instr == '0)); // R7
endmodule

// File: tb/fetch_exec_seq_tb.sv
module fetch_exec_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 14;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pmem_addr;
  logic [IW-1:0] pmem_data;
  logic          test_bit = 1'b0;
  logic [IW-1:0] exec_instr;
  logic          exec_valid;

  logic [IW-1:0] prog [DEPTH];
  int n_tests = 0;
  int n_fail  = 0;

  logic [AW-1:0] e_pc;
  logic          e_valid;
  logic [AW-1:0] e_xaddr;
  string         e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign pmem_data = prog[pmem_addr];

  fetch_exec_seq dut_i (
    .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .test_bit(test_bit), .exec_instr(exec_instr), .exec_valid(exec_valid)
  );

  function automatic logic [IW-1:0] mk(input logic [2:0] op, input logic [AW-1:0] f);
    return {op, f};
  endfunction

  function automatic logic [IW-1:0] rand_word();
    int r = $urandom_range(99);
    logic [2:0] others [5] = '{3'b001, 3'b011, 3'b100, 3'b110, 3'b111};
    logic [AW-1:0] f = AW'($urandom);
    if (r < 10) return '0;
    if (r < 25) return mk(3'b101, f);
    if (r < 50) return mk(3'b010, f);
    return mk(others[$urandom_range(4)], f);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_cycle();
    check(e_tag, "exec_valid", 32'(exec_valid), 32'(e_valid));
    check(e_tag, "pmem_addr", 32'(pmem_addr), 32'(e_pc));
    if (e_valid) check("R3", "exec_instr", 32'(exec_instr), 32'(prog[e_xaddr]));
    else         check("R7", "null exec_instr", 32'(exec_instr), 32'd0);
  endtask

  task automatic step_model(input logic tb);
    logic [IW-1:0] w = e_valid ? prog[e_xaddr] : '0;
    logic [2:0] op = w[IW-1:IW-3];
    if (e_valid && op == 3'b101) begin
      e_tag = "R4"; e_pc = w[AW-1:0]; e_valid = 1'b0;
    end else if (e_valid && op == 3'b010 && !tb) begin
      e_tag = "R5"; e_pc = e_pc + AW'(1); e_valid = 1'b0;
    end else begin
      if (e_valid && op == 3'b010) e_tag = "R6";
      else if (e_pc == '1)         e_tag = "R8";
      else if (!e_valid)           e_tag = "R1";
      else                         e_tag = "R2";
      e_xaddr = e_pc; e_pc = e_pc + AW'(1); e_valid = 1'b1;
    end
  endtask

  task automatic run(input int cycles, input bit rnd_tb, input logic fixed_tb);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset pmem_addr", 32'(pmem_addr), 32'd0);
    check("R1", "reset exec_valid", 32'(exec_valid), 32'd0);
    rst_n = 1'b1;
    e_pc = '0; e_valid = 1'b0; e_xaddr = '0; e_tag = "R1";
    for (int c = 0; c < cycles; c++) begin
      check_cycle();
      test_bit = rnd_tb ? 1'($urandom) : fixed_tb;
      step_model(test_bit);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) prog[i] = mk(3'b001, AW'(i));
    prog[0] = '0;
    prog[1] = mk(3'b010, 11'h0);
    prog[2] = mk(3'b100, 11'h5);
    prog[3] = mk(3'b010, 11'h1);
    prog[4] = mk(3'b110, 11'h2);
    prog[5] = mk(3'b101, 11'h7FD);
    prog[11'h7FD] = mk(3'b010, 11'h3);
    prog[11'h7FF] = mk(3'b111, 11'h4);
    run(14, 1'b0, 1'b0);
    run(14, 1'b0, 1'b1);
    for (int i = 0; i < DEPTH; i++) prog[i] = rand_word();
    run(4000, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) prog[i] = rand_word();
    run(4000, 1'b1, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule